// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block watches three streams coming out of a processor: the address and data of each bus transfer, and the program counter of each executed instruction. It compares them against software-loaded reference values. Each reference has a per-bit mask that takes chosen bits out of the comparison. The program counter has several reference slots that share one mask. The results are combined into a programmable trigger, and the trigger raises either a halt request or a debug interrupt request toward the processor.

A trigger is built in one of two ways. In one-level mode a single condition fires it. In two-level mode a first condition arms the unit, and a second condition seen on a later cycle fires it. Each level picks any combination of address, data and PC hits, and all of the picked hits must be present at once. After a trigger fires the unit holds a sticky status and stays silent until software clears that status. Configuration enters through a simple write port, which can be fed by a debug channel or by a privileged software interface.

Top module: `brk_trig_top`

## Requirements
- R1: After reset all outputs are low, the unit is idle, every reference and mask register holds zero and the control word is zero (trigger disabled).
- R2: The address and data conditions hit only in a cycle with `bus_valid` high, and the PC conditions only with `pc_valid` high. A condition hits when ((value XOR reference) AND NOT mask) is zero, so a mask bit of 1 removes that bit from the comparison.
- R3: The PC condition hits when any of the four PC references matches the PC under the single shared PC mask.
- R4: A level's condition is the AND of the hits it selects through a 3-bit select field (bit 0 address, bit 1 data, bit 2 PC). A select field of zero never hits.
- R5: In one-level mode, with the trigger enabled, a level-1 hit makes the selected action output pulse high for exactly one cycle, on the clock edge that samples the hit.
- R6: In two-level mode a level-1 hit in the idle state sets `trig_armed` on the sampling edge and does not fire, even when level 2 hits in the same cycle. A later level-2 hit fires the action and clears `trig_armed`.
- R7: The armed state persists until the trigger fires or a configuration write to select codes 0 to 9 lands. Such a write returns the unit to idle, and in that write cycle no hit arms or fires.
- R8: Control bit 7 chooses the action: 0 pulses `trig_halt`, 1 pulses `trig_irq`. The two outputs are never high together.
- R9: Firing sets `trig_hold` together with the pulse. While `trig_hold` is high no further trigger fires, and configuration writes leave it set. It clears only on a write to select code 10.
- R10: Control bit 8 is the enable. With it at 0 the unit neither arms nor fires.
- R11: Write select codes: 0 address reference, 1 address mask, 2 data reference, 3 data mask, 4 to 7 PC references 0 to 3, 8 PC mask, 9 control, 10 status clear. Codes 11 to 15 are ignored. Control word: bits 2:0 level-1 select, bits 5:3 level-2 select, bit 6 two-level mode, bit 7 action, bit 8 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select code for the write |
| cfg_wdata | input | 32 | Write data |
| bus_valid | input | 1 | Bus address and data are valid this cycle |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| pc_valid | input | 1 | Program counter is valid this cycle |
| pc_val | input | 32 | Program counter |
| trig_halt | output | 1 | One-cycle halt request |
| trig_irq | output | 1 | One-cycle debug interrupt request |
| trig_armed | output | 1 | Two-level trigger is armed |
| trig_hold | output | 1 | Sticky fired status |

## Verification
The bench probes the masked comparators at their edges: a value that differs only in masked bits must hit, a value one unmasked bit away must miss, and a matching value with its valid strobe low must miss. A design that inverted the mask sense or ignored the strobes would then fire where none is expected. In two-level mode it presents both level conditions in the idle cycle, where a design that skipped the arming step would fire early. It lets the armed state sit through idle cycles, an ignored select code and a status clear, where a leaky design would drop it, and it lands a configuration write on the same cycle as a level-1 hit, where a design that let the write through would arm. It also repeats hits and writes while the status is held, where a design that re-fires or lets a configuration write clear the status would pulse or drop `trig_hold`.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic       en;       // bit 8
    logic       act_irq;  // bit 7
    logic       two_lvl;  // bit 6
    logic [2:0] l2_sel;   // bits 5:3
    logic [2:0] l1_sel;   // bits 2:0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } seq_st_e;

  // Condition vector order: {pc, data, addr}.
  function automatic logic lvl_match(logic [2:0] sel, logic [2:0] hits);
    return (|sel) && ((sel & hits) == sel);
  endfunction

endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int DW = 32
) (
  input  logic          vld,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] ref_val,
  input  logic [DW-1:0] msk,
  output logic          hit
);
  logic [DW-1:0] diff;

  always_comb begin
    diff = (val ^ ref_val) & ~msk;
    hit  = vld && (diff == '0);
  end
endmodule

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPC   = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    a_ref,
  output logic [DW-1:0]    a_msk,
  output logic [DW-1:0]    d_ref,
  output logic [DW-1:0]    d_msk,
  output logic [DW-1:0]    pc_ref [NPC],
  output logic [DW-1:0]    pc_msk,
  output ctrl_t            ctrl,
  output logic             reconf,
  output logic             clr
);
  localparam int CODE_AREF  = 0;
  localparam int CODE_AMSK  = 1;
  localparam int CODE_DREF  = 2;
  localparam int CODE_DMSK  = 3;
  localparam int CODE_PC0   = 4;
  localparam int CODE_PCMSK = CODE_PC0 + NPC;
  localparam int CODE_CTRL  = CODE_PCMSK + 1;
  localparam int CODE_CLR   = CODE_CTRL + 1;

  logic en_aref, en_amsk, en_dref, en_dmsk, en_pcmsk, en_ctrl;

  // Write enables, one per register.
  always_comb begin
    en_aref  = we && (sel == SEL_W'(CODE_AREF));
    en_amsk  = we && (sel == SEL_W'(CODE_AMSK));
    en_dref  = we && (sel == SEL_W'(CODE_DREF));
    en_dmsk  = we && (sel == SEL_W'(CODE_DMSK));
    en_pcmsk = we && (sel == SEL_W'(CODE_PCMSK));
    en_ctrl  = we && (sel == SEL_W'(CODE_CTRL));
    reconf   = we && (sel <  SEL_W'(CODE_CLR));
    clr      = we && (sel == SEL_W'(CODE_CLR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ref <= '0;
    end else if (en_aref) begin
      a_ref <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_msk <= '0;
    end else if (en_amsk) begin
      a_msk <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_ref <= '0;
    end else if (en_dref) begin
      d_ref <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_msk <= '0;
    end else if (en_dmsk) begin
      d_msk <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_msk <= '0;
    end else if (en_pcmsk) begin
      pc_msk <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (en_ctrl) begin
      ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  for (genvar g = 0; g < NPC; g++) begin : g_pc
    logic          en_pc;
    logic [DW-1:0] pc_q;

    assign en_pc = we && (sel == SEL_W'(CODE_PC0 + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q <= '0;
      end else if (en_pc) begin
        pc_q <= wdata;
      end
    end

    assign pc_ref[g] = pc_q;
  end

  // Control bits above CTRL_W are not stored.
  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:CTRL_W];
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  l1_hit,
  input  logic  l2_hit,
  input  logic  reconf,
  input  logic  clr,
  output logic  armed,
  output logic  hold,
  output logic  halt_p,
  output logic  irq_p
);
  seq_st_e st_q, st_d;
  logic    fire;
  logic    halt_q, irq_q;

  // Next-state process.
  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    case (st_q)
      ST_FIRED: begin
        if (clr) st_d = ST_IDLE;
      end
      default: begin
        if (reconf || !ctrl.en) begin
          st_d = ST_IDLE;
        end else if (!ctrl.two_lvl) begin
          if (l1_hit) begin
            st_d = ST_FIRED;
            fire = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else if (st_q == ST_IDLE) begin
          if (l1_hit) st_d = ST_ARMED;
        end else if (l2_hit) begin
          st_d = ST_FIRED;
          fire = 1'b1;
        end
      end
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      halt_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      halt_q <= fire && !ctrl.act_irq;
      irq_q  <= fire &&  ctrl.act_irq;
    end
  end

  assign armed  = (st_q == ST_ARMED);
  assign hold   = (st_q == ST_FIRED);
  assign halt_p = halt_q;
  assign irq_p  = irq_q;
endmodule

// File: rtl/brk_trig_top.sv
module brk_trig_top
  import brk_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int NPC   = 4,
  localparam int SEL_W = $clog2(NPC + 7)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             bus_valid,
  input  logic [DW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             pc_valid,
  input  logic [DW-1:0]    pc_val,
  output logic             trig_halt,
  output logic             trig_irq,
  output logic             trig_armed,
  output logic             trig_hold
);
  logic          rst_n_s;
  logic [DW-1:0] a_ref, a_msk, d_ref, d_msk, pc_msk;
  logic [DW-1:0] pc_ref [NPC];
  ctrl_t         ctrl;
  logic          reconf, clr;
  logic          a_hit, d_hit, pc_hit;
  logic [NPC-1:0] pc_hits;
  logic [2:0]    hits;
  logic          l1_hit, l2_hit;

  brk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  brk_cfg_regs #(.DW(DW), .NPC(NPC), .SEL_W(SEL_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .a_ref  (a_ref),
    .a_msk  (a_msk),
    .d_ref  (d_ref),
    .d_msk  (d_msk),
    .pc_ref (pc_ref),
    .pc_msk (pc_msk),
    .ctrl   (ctrl),
    .reconf (reconf),
    .clr    (clr)
  );

  brk_match #(.DW(DW)) u_amatch (
    .vld     (bus_valid),
    .val     (bus_addr),
    .ref_val (a_ref),
    .msk     (a_msk),
    .hit     (a_hit)
  );

  brk_match #(.DW(DW)) u_dmatch (
    .vld     (bus_valid),
    .val     (bus_data),
    .ref_val (d_ref),
    .msk     (d_msk),
    .hit     (d_hit)
  );

  for (genvar g = 0; g < NPC; g++) begin : g_pcm
    brk_match #(.DW(DW)) u_pcmatch (
      .vld     (pc_valid),
      .val     (pc_val),
      .ref_val (pc_ref[g]),
      .msk     (pc_msk),
      .hit     (pc_hits[g])
    );
  end

  always_comb begin
    pc_hit = |pc_hits;
    hits   = {pc_hit, d_hit, a_hit};
    l1_hit = lvl_match(ctrl.l1_sel, hits);
    l2_hit = lvl_match(ctrl.l2_sel, hits);
  end

  brk_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ctrl   (ctrl),
    .l1_hit (l1_hit),
    .l2_hit (l2_hit),
    .reconf (reconf),
    .clr    (clr),
    .armed  (trig_armed),
    .hold   (trig_hold),
    .halt_p (trig_halt),
    .irq_p  (trig_irq)
  );
endmodule

// File: rtl/brk_trig_chk.sv
module brk_trig_chk #(
  parameter  int NPC   = 4,
  localparam int SEL_W = $clog2(NPC + 7)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             trig_halt,
  input logic             trig_irq,
  input logic             trig_armed,
  input logic             trig_hold
);
  localparam logic [SEL_W-1:0] CLR_CODE = SEL_W'(NPC + 6);

  // R5: a trigger pulse lasts one cycle
  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_halt || trig_irq) |=> !(trig_halt || trig_irq));

  // R8: the two actions are exclusive
  a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_halt && trig_irq));

  // R9: the sticky status rises with the pulse
  a_r9_hold_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_halt || trig_irq) |-> trig_hold);

  // R9: no trigger while held
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hold |=> !(trig_halt || trig_irq));

  // R9: only a status-clear write releases the hold
  a_r9_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hold && !(cfg_we && cfg_sel == CLR_CODE)) |=> trig_hold);

  // R7: a configuration write disarms and blocks firing
  a_r7_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel < CLR_CODE && !trig_hold) |=>
      (!trig_armed && !trig_halt && !trig_irq));

  // R6: armed and fired are distinct states
  a_r6_armed_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_armed && trig_hold));
endmodule

bind brk_trig_top brk_trig_chk #(.NPC(NPC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .trig_halt  (trig_halt),
  .trig_irq   (trig_irq),
  .trig_armed (trig_armed),
  .trig_hold  (trig_hold)
);

// File: tb/sim_brk_trig_top.sv
`timescale 1ns/1ps
module sim_brk_trig_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        bus_valid;
  logic [31:0] bus_addr, bus_data;
  logic        pc_valid;
  logic [31:0] pc_val;
  logic        trig_halt, trig_irq, trig_armed, trig_hold;

  typedef struct {
    logic  h;
    logic  i;
    logic  a;
    logic  hd;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  brk_trig_top u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .pc_valid(pc_valid), .pc_val(pc_val),
    .trig_halt(trig_halt), .trig_irq(trig_irq),
    .trig_armed(trig_armed), .trig_hold(trig_hold)
  );

  task automatic cmp(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // Monitor: one expected item per driven cycle, compared after the edge.
  exp_t e;
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "trig_halt",  trig_halt,  e.h);
      cmp(e.tag, "trig_irq",   trig_irq,   e.i);
      cmp(e.tag, "trig_armed", trig_armed, e.a);
      cmp(e.tag, "trig_hold",  trig_hold,  e.hd);
    end
  end

  task automatic drive(logic bv, logic [31:0] ba, logic [31:0] bd,
                       logic pv, logic [31:0] pcv,
                       logic we, logic [3:0] s, logic [31:0] wd,
                       logic eh, logic ei, logic ea, logic ehd, string tag);
    @(negedge clk);
    bus_valid = bv; bus_addr = ba; bus_data = bd;
    pc_valid = pv;  pc_val = pcv;
    cfg_we = we;    cfg_sel = s;   cfg_wdata = wd;
    q.push_back('{h: eh, i: ei, a: ea, hd: ehd, tag: tag});
  endtask

  task automatic wr(logic [3:0] s, logic [31:0] d, logic ehd, string tag);
    drive(1'b0, '0, '0, 1'b0, '0, 1'b1, s, d, 1'b0, 1'b0, 1'b0, ehd, tag);
  endtask

  task automatic bus(logic [31:0] a, logic [31:0] d,
                     logic eh, logic ei, logic ea, logic ehd, string tag);
    drive(1'b1, a, d, 1'b0, '0, 1'b0, '0, '0, eh, ei, ea, ehd, tag);
  endtask

  task automatic pc(logic [31:0] p, logic eh, logic ei, logic ea, logic ehd, string tag);
    drive(1'b0, '0, '0, 1'b1, p, 1'b0, '0, '0, eh, ei, ea, ehd, tag);
  endtask

  task automatic idle(logic eh, logic ei, logic ea, logic ehd, string tag);
    drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, '0, eh, ei, ea, ehd, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_data = '0;
    pc_valid = 1'b0; pc_val = '0;
    repeat (3) @(negedge clk);
    cmp("R1", "trig_halt",  trig_halt,  1'b0);
    cmp("R1", "trig_irq",   trig_irq,   1'b0);
    cmp("R1", "trig_armed", trig_armed, 1'b0);
    cmp("R1", "trig_hold",  trig_hold,  1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: zero references and masks after reset
    wr(4'd9, 32'h101, 1'b0, "R1");
    bus(32'h1, '0, 0, 0, 0, 0, "R1");
    bus(32'h0, '0, 1, 0, 0, 1, "R1");
    idle(0, 0, 0, 1, "R5");
    wr(4'd10, '0, 1'b0, "R9");

    // R2 / R5: masked address match, one-cycle pulse
    wr(4'd0, 32'h1000_0040, 1'b0, "R11");
    wr(4'd1, 32'h0000_000F, 1'b0, "R11");
    bus(32'h1000_004C, '0, 1, 0, 0, 1, "R2");
    idle(0, 0, 0, 1, "R5");
    // R9: hold blocks re-trigger, config write keeps hold
    bus(32'h1000_0040, '0, 0, 0, 0, 1, "R9");
    wr(4'd0, 32'h1000_0040, 1'b1, "R9");
    wr(4'd10, '0, 1'b0, "R9");
    // R2: unmasked bit differs, and strobe low
    bus(32'h1000_0050, '0, 0, 0, 0, 0, "R2");
    drive(1'b0, 32'h1000_0040, '0, 1'b0, '0, 1'b0, '0, '0, 0, 0, 0, 0, "R2");

    // R8: interrupt action
    wr(4'd9, 32'h181, 1'b0, "R8");
    bus(32'h1000_0041, '0, 0, 1, 0, 1, "R8");
    idle(0, 0, 0, 1, "R8");
    wr(4'd10, '0, 1'b0, "R8");

    // R4: address AND data
    wr(4'd2, 32'hDEAD_BEEF, 1'b0, "R11");
    wr(4'd3, 32'hFFFF_0000, 1'b0, "R11");
    wr(4'd9, 32'h103, 1'b0, "R4");
    bus(32'h1000_0040, 32'h1234_BEEE, 0, 0, 0, 0, "R4");
    bus(32'h1000_0060, 32'h1234_BEEF, 0, 0, 0, 0, "R4");
    bus(32'h1000_0040, 32'h1234_BEEF, 1, 0, 0, 1, "R4");
    wr(4'd10, '0, 1'b0, "R4");
    // R4: empty selection never hits
    wr(4'd9, 32'h100, 1'b0, "R4");
    bus(32'h1000_0040, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4");

    // R3: four PC references, shared mask
    wr(4'd4, 32'h100, 1'b0, "R11");
    wr(4'd5, 32'h200, 1'b0, "R11");
    wr(4'd6, 32'h300, 1'b0, "R11");
    wr(4'd7, 32'h400, 1'b0, "R11");
    wr(4'd8, 32'h3,   1'b0, "R11");
    wr(4'd9, 32'h104, 1'b0, "R3");
    pc(32'h302, 1, 0, 0, 1, "R3");
    wr(4'd10, '0, 1'b0, "R3");
    pc(32'h404, 0, 0, 0, 0, "R3");
    drive(1'b0, '0, '0, 1'b0, 32'h100, 1'b0, '0, '0, 0, 0, 0, 0, "R2");
    pc(32'h403, 1, 0, 0, 1, "R3");
    wr(4'd10, '0, 1'b0, "R3");
    pc(32'h101, 1, 0, 0, 1, "R3");
    wr(4'd10, '0, 1'b0, "R3");

    // R10: disabled
    wr(4'd9, 32'h004, 1'b0, "R10");
    pc(32'h100, 0, 0, 0, 0, "R10");

    // R6: two-level, level 1 = PC, level 2 = address, irq action
    wr(4'd9, 32'h1CC, 1'b0, "R6");
    bus(32'h1000_0040, '0, 0, 0, 0, 0, "R6");
    drive(1'b1, 32'h1000_0040, '0, 1'b1, 32'h100, 1'b0, '0, '0, 0, 0, 1, 0, "R6");
    idle(0, 0, 1, 0, "R7");
    idle(0, 0, 1, 0, "R7");
    wr(4'd13, 32'hFFFF_FFFF, 1'b0, "R11");
    q[q.size()-1].a = 1'b1;
    wr(4'd10, '0, 1'b0, "R11");
    q[q.size()-1].a = 1'b1;
    pc(32'h200, 0, 0, 1, 0, "R6");
    bus(32'h1000_0048, '0, 0, 1, 0, 1, "R6");
    wr(4'd10, '0, 1'b0, "R9");

    // R7: write disarms, write cycle blocks arming
    pc(32'h200, 0, 0, 1, 0, "R6");
    wr(4'd1, 32'h0000_000F, 1'b0, "R7");
    bus(32'h1000_0040, '0, 0, 0, 0, 0, "R7");
    drive(1'b0, '0, '0, 1'b1, 32'h100, 1'b1, 4'd8, 32'h3, 0, 0, 0, 0, "R7");
    idle(0, 0, 0, 0, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule